// File: doc/BRIEF.md
# Fail-Safe Trigger Pulse Conditioner

This block sits on the receiving side of an isolated trigger path. It takes three kinds of asynchronous input: a raw trigger line that carries events, a separate permission level, and a set of domain-health levels that report whether the far side is powered, whether the trigger line is actually driven, and whether health flags are valid. Each input passes through a two-flop synchronizer. The event line then goes through a width qualifier that rejects short glitches. Qualified events must pass a minimum-spacing check and a token-bucket rate limit. Each accepted event becomes one output pulse of fixed width. Its start time is captured by a free-running hardware counter and offered on a valid/ready timestamp stream.

The output is forced low whenever permission is missing, any health level is bad, or reset is still in progress. A registered reason code names the highest-priority cause of the inhibit. Events that qualify while the block is permitted, but are refused by the spacing, rate or timestamp-slot rules, increment a saturating drop counter.

The timestamp stream has a single slot. The slot holds its word, unchanged, until `ts_ready` is sampled high. Back-pressure never stalls the trigger path. An event that qualifies while the slot is full and is not being emptied in that cycle is dropped and counted.

Top module: `trig_pulse_conditioner`

## Requirements
- R1: While `rst_n` is low, and for a short settle period after it rises, `trig_out` is 0, `inhibit_reason` is 1 (reset hold), `ts_valid` is 0 and `drop_count` is 0. Because every synchronizer resets to 0, a missing input defaults to inhibit.
- R2: A raw trigger pulse that lasts N clock cycles is qualified exactly when N >= W, where W = max(`cfg_min_width`, 1). When the event is accepted, `trig_out` rises 2+W cycles after the raw rising edge.
- R3: Each accepted event drives `trig_out` high for exactly OUT_WIDTH cycles. An input held high for any length of time yields only one event.
- R4: A qualified event is refused when fewer than `cfg_min_gap` cycles have passed since the qualification of the previous accepted event. It is also refused while an output pulse is still active.
- R5: The rate limit is a token bucket holding BURST tokens. It starts full and gains one token every `cfg_refill` cycles while it is not full. A value of 0 or 1 refills every cycle. Each accepted event uses one token, and an event that arrives with the bucket empty is refused.
- R6: `drop_count` increments for each qualified event that is refused under R4, R5 or R10 while the block is permitted. The count saturates at all ones and never decreases. Events that qualify while the block is inhibited are not counted.
- R7: `inhibit_reason` encodes the cause as follows: 0 means none, 1 reset hold, 2 far side unpowered, 3 trigger line open, 4 health invalid, 5 permission absent. When several causes are present, the lowest nonzero code wins. The code follows a change on an input 3 cycles later.
- R8: `trig_out` is high only while `inhibit_reason` is 0. A pulse in progress is cut off in the first cycle the reason becomes nonzero and is discarded, so it does not resume when permission returns.
- R9: For each accepted event, `ts_valid` rises in the first high cycle of `trig_out`. At that point `ts_data` holds the number of clock edges counted since `rst_n` was released.
- R10: When `ts_valid` is 1 and `ts_ready` is 0, `ts_valid` and `ts_data` are held at the next edge. An event that qualifies while the slot is full and not being popped in that cycle produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in_raw | input | 1 | Raw event line, asynchronous |
| permit_in_raw | input | 1 | Permission level, asynchronous, high means allow |
| peer_pwr_ok_raw | input | 1 | Far-side powered indication, asynchronous |
| line_ok_raw | input | 1 | Trigger line driven (not open), asynchronous |
| health_ok_raw | input | 1 | Health flags valid, asynchronous |
| cfg_min_width | input | CW | Minimum accepted input width in cycles |
| cfg_min_gap | input | GW | Minimum spacing between accepted events in cycles |
| cfg_refill | input | RW | Cycles per token refill |
| trig_out | output | 1 | Conditioned trigger pulse |
| inhibit_reason | output | 3 | Current inhibit cause (R7) |
| ts_valid | output | 1 | Timestamp word available |
| ts_ready | input | 1 | Consumer takes the timestamp word |
| ts_data | output | TSW | Edge timestamp |
| drop_count | output | DROP_W | Saturating refused-event count |

## Verification
The width qualifier is swept over every pairing of a small set of minimum widths with raw pulse lengths from one cycle up to beyond the limit. This separates off-by-one rejection from correct rejection, and it pins down the output latency and the stretched width. Pulse pairs are placed at offsets on both sides of the spacing limit, and a regular pulse train runs faster than the refill rate. Together these show that the gap rule and the bucket each refuse exactly the expected events, and that the drop counter follows them up to saturation. Each health and permission input is dropped alone and then in combination to expose the reason priority. The permission line is also dropped in the middle of a pulse to show the cut-off and that the pulse does not resume.

// File: rtl/trig_cond_pkg.sv
package trig_cond_pkg;
  typedef enum logic [2:0] {
    INH_NONE      = 3'd0,
    INH_RESET     = 3'd1,
    INH_PEER_OFF  = 3'd2,
    INH_LINE_OPEN = 3'd3,
    INH_HEALTH    = 3'd4,
    INH_NO_PERMIT = 3'd5
  } inh_reason_e;
endpackage

// File: rtl/tc_sync_bank.sv
module tc_sync_bank #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1[i] <= 1'b0;
        q_sync[i] <= 1'b0;
      end else begin
        stage1[i] <= d_async[i];
        q_sync[i] <= stage1[i];
      end
    end
  end
endmodule

// File: rtl/tc_width_qual.sv
module tc_width_qual #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          level,
  input  logic [CW-1:0] cfg_min_width,
  output logic          qual
);
  logic [CW-1:0] run_cnt;
  logic [CW-1:0] eff_width;

  // zero is treated as one cycle
  assign eff_width = (cfg_min_width == '0) ? CW'(1) : cfg_min_width;
  // fires once, on the cycle the high run reaches the limit
  assign qual = level && (run_cnt == eff_width - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               run_cnt <= '0;
    else if (!level)          run_cnt <= '0;
    else if (run_cnt != '1)   run_cnt <= run_cnt + CW'(1);
  end
endmodule

// File: rtl/tc_event_gate.sv
module tc_event_gate #(
  parameter int GW     = 12,
  parameter int RW     = 16,
  parameter int BURST  = 4,
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qual,
  input  logic              permit,
  input  logic              busy,
  input  logic              slot_free,
  input  logic [GW-1:0]     cfg_min_gap,
  input  logic [RW-1:0]     cfg_refill,
  output logic              accept,
  output logic [DROP_W-1:0] drop_count
);
  localparam int TW = $clog2(BURST + 1);

  logic [GW-1:0] gap_cnt;
  logic [TW-1:0] tokens;
  logic [RW-1:0] refill_cnt;
  logic          gap_ok, bucket_full, tick, refuse;

  assign gap_ok      = (gap_cnt <= GW'(1));
  assign bucket_full = (tokens == TW'(BURST));
  assign tick        = !bucket_full &&
                       ((cfg_refill <= RW'(1)) || (refill_cnt == cfg_refill - RW'(1)));
  assign accept      = qual && permit && gap_ok && (tokens != '0) && slot_free && !busy;
  assign refuse      = qual && permit && !accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap_cnt <= '0;
    else if (accept)           gap_cnt <= cfg_min_gap;
    else if (gap_cnt != '0)    gap_cnt <= gap_cnt - GW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tokens     <= TW'(BURST);
      refill_cnt <= '0;
    end else begin
      if (accept && !tick)      tokens <= tokens - TW'(1);
      else if (tick && !accept) tokens <= tokens + TW'(1);
      if (bucket_full || tick) refill_cnt <= '0;
      else                     refill_cnt <= refill_cnt + RW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          drop_count <= '0;
    else if (refuse && drop_count != '1) drop_count <= drop_count + DROP_W'(1);
  end
endmodule

// File: rtl/tc_stretch_ts.sv
module tc_stretch_ts #(
  parameter int OUT_W = 8,
  parameter int TSW   = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic           permit,
  input  logic           ts_ready,
  output logic           trig_out,
  output logic           busy,
  output logic           slot_free,
  output logic           ts_valid,
  output logic [TSW-1:0] ts_data
);
  localparam int SW = $clog2(OUT_W + 1);

  logic [SW-1:0]  str_cnt;
  logic [TSW-1:0] time_cnt;

  assign busy      = (str_cnt != '0);
  assign trig_out  = busy && permit;
  assign slot_free = !ts_valid || ts_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_cnt <= '0;
    else        time_cnt <= time_cnt + TSW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           str_cnt <= '0;
    else if (!permit)     str_cnt <= '0;
    else if (accept)      str_cnt <= SW'(OUT_W);
    else if (busy)        str_cnt <= str_cnt - SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_valid <= 1'b0;
      ts_data  <= '0;
    end else if (accept) begin
      ts_valid <= 1'b1;
      ts_data  <= time_cnt + TSW'(1);
    end else if (ts_ready) begin
      ts_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tc_fault_arb.sv
module tc_fault_arb
  import trig_cond_pkg::*;
#(
  parameter int SETTLE = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        peer_pwr_ok,
  input  logic        line_ok,
  input  logic        health_ok,
  input  logic        permit_lvl,
  output inh_reason_e reason,
  output logic        permit
);
  localparam int STW = $clog2(SETTLE + 1);

  logic [STW-1:0] settle_cnt;
  inh_reason_e    reason_nx;

  always_comb begin
    if (settle_cnt != '0)  reason_nx = INH_RESET;
    else if (!peer_pwr_ok) reason_nx = INH_PEER_OFF;
    else if (!line_ok)     reason_nx = INH_LINE_OPEN;
    else if (!health_ok)   reason_nx = INH_HEALTH;
    else if (!permit_lvl)  reason_nx = INH_NO_PERMIT;
    else                   reason_nx = INH_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_cnt <= STW'(SETTLE);
      reason     <= INH_RESET;
    end else begin
      if (settle_cnt != '0) settle_cnt <= settle_cnt - STW'(1);
      reason <= reason_nx;
    end
  end

  assign permit = (reason == INH_NONE);
endmodule

// File: rtl/trig_pulse_conditioner.sv
module trig_pulse_conditioner
  import trig_cond_pkg::*;
#(
  parameter int CW     = 8,
  parameter int GW     = 12,
  parameter int RW     = 16,
  parameter int BURST  = 4,
  parameter int OUT_W  = 8,
  parameter int TSW    = 32,
  parameter int DROP_W = 8,
  parameter int SETTLE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_in_raw,
  input  logic              permit_in_raw,
  input  logic              peer_pwr_ok_raw,
  input  logic              line_ok_raw,
  input  logic              health_ok_raw,
  input  logic [CW-1:0]     cfg_min_width,
  input  logic [GW-1:0]     cfg_min_gap,
  input  logic [RW-1:0]     cfg_refill,
  output logic              trig_out,
  output logic [2:0]        inhibit_reason,
  output logic              ts_valid,
  input  logic              ts_ready,
  output logic [TSW-1:0]    ts_data,
  output logic [DROP_W-1:0] drop_count
);
  localparam int NSYNC = 5;

  logic [NSYNC-1:0] raw_bus, syn_bus;
  logic             trig_s, permit_s, pwr_s, line_s, health_s;
  logic             qual, accept, permit, busy, slot_free;
  inh_reason_e      reason;

  assign raw_bus = {trig_in_raw, permit_in_raw, peer_pwr_ok_raw, line_ok_raw, health_ok_raw};
  assign {trig_s, permit_s, pwr_s, line_s, health_s} = syn_bus;
  assign inhibit_reason = reason;

  tc_sync_bank #(.WIDTH(NSYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(raw_bus), .q_sync(syn_bus)
  );

  tc_fault_arb #(.SETTLE(SETTLE)) u_arb (
    .clk(clk), .rst_n(rst_n), .peer_pwr_ok(pwr_s), .line_ok(line_s),
    .health_ok(health_s), .permit_lvl(permit_s), .reason(reason), .permit(permit)
  );

  tc_width_qual #(.CW(CW)) u_qual (
    .clk(clk), .rst_n(rst_n), .level(trig_s), .cfg_min_width(cfg_min_width), .qual(qual)
  );

  tc_event_gate #(.GW(GW), .RW(RW), .BURST(BURST), .DROP_W(DROP_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .qual(qual), .permit(permit), .busy(busy),
    .slot_free(slot_free), .cfg_min_gap(cfg_min_gap), .cfg_refill(cfg_refill),
    .accept(accept), .drop_count(drop_count)
  );

  tc_stretch_ts #(.OUT_W(OUT_W), .TSW(TSW)) u_out (
    .clk(clk), .rst_n(rst_n), .accept(accept), .permit(permit), .ts_ready(ts_ready),
    .trig_out(trig_out), .busy(busy), .slot_free(slot_free),
    .ts_valid(ts_valid), .ts_data(ts_data)
  );
endmodule

// File: rtl/trig_cond_checker.sv
module trig_cond_checker #(
  parameter int OUT_W  = 8,
  parameter int TSW    = 32,
  parameter int DROP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_out,
  input logic [2:0]        inhibit_reason,
  input logic              ts_valid,
  input logic              ts_ready,
  input logic [TSW-1:0]    ts_data,
  input logic [DROP_W-1:0] drop_count
);
  logic [31:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_run <= '0;
    else if (trig_out) hi_run <= hi_run + 32'd1;
    else               hi_run <= '0;
  end

  // R8
  out_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> (inhibit_reason == 3'd0));

  // R3
  stretch_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> (hi_run < 32'(OUT_W)));

  // R10
  ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_valid && !ts_ready) |=> (ts_valid && $stable(ts_data)));

  // R9
  ts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_out) |-> ts_valid);

  // R6
  drop_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (drop_count >= $past(drop_count)));
endmodule

bind trig_pulse_conditioner trig_cond_checker #(
  .OUT_W(OUT_W), .TSW(TSW), .DROP_W(DROP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_out(trig_out), .inhibit_reason(inhibit_reason),
  .ts_valid(ts_valid), .ts_ready(ts_ready), .ts_data(ts_data), .drop_count(drop_count)
);

// File: tb/sim_trig_pulse_conditioner.sv
`timescale 1ns/1ps
module sim_trig_pulse_conditioner;
  localparam int OUT_W  = 16;
  localparam int DROP_W = 3;
  localparam int SAT    = (1 << DROP_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_raw = 1'b0, permit_raw = 1'b0, pwr_raw = 1'b0, line_raw = 1'b0, health_raw = 1'b0;
  logic [7:0]  cfg_min_width = 8'd1;
  logic [11:0] cfg_min_gap = 12'd0;
  logic [15:0] cfg_refill = 16'd1;
  logic        trig_out, ts_valid;
  logic        ts_ready = 1'b1;
  logic [2:0]  inhibit_reason;
  logic [31:0] ts_data;
  logic [DROP_W-1:0] drop_count;

  int checks = 0, errors = 0, exp_drop = 0;
  longint bt;
  int st[10]; int nst;
  int rises, hi_total;
  int rise_at[10]; longint ts_seen[10]; longint ts_exp[10]; bit tsv[10];
  bit done = 0;

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) bt <= 0; else bt <= bt + 1;

  trig_pulse_conditioner #(.OUT_W(OUT_W), .DROP_W(DROP_W)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_in_raw(trig_raw), .permit_in_raw(permit_raw),
    .peer_pwr_ok_raw(pwr_raw), .line_ok_raw(line_raw), .health_ok_raw(health_raw),
    .cfg_min_width(cfg_min_width), .cfg_min_gap(cfg_min_gap), .cfg_refill(cfg_refill),
    .trig_out(trig_out), .inhibit_reason(inhibit_reason), .ts_valid(ts_valid),
    .ts_ready(ts_ready), .ts_data(ts_data), .drop_count(drop_count)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_seq(input int pw, input int watch);
    bit prev = 0;
    rises = 0; hi_total = 0;
    for (int i = 0; i < watch; i++) begin
      bit drv = 0;
      @(negedge clk);
      if (trig_out) hi_total++;
      if (trig_out && !prev) begin
        if (rises < 10) begin
          rise_at[rises] = i; ts_seen[rises] = ts_data; ts_exp[rises] = bt; tsv[rises] = ts_valid;
        end
        rises++;
      end
      prev = trig_out;
      for (int k = 0; k < nst; k++) if (i >= st[k] && i < st[k] + pw) drv = 1;
      trig_raw = drv;
    end
    trig_raw = 0;
  endtask

  function automatic int sat_drop(input int e);
    return (e > SAT) ? SAT : e;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    idle(3);
    check(trig_out == 0 && inhibit_reason == 3'd1, "R1 reset out/reason", inhibit_reason, 1);
    check(ts_valid == 0 && drop_count == 0, "R1 reset ts/drop", drop_count, 0);
    permit_raw = 1; pwr_raw = 1; line_raw = 1; health_raw = 1;
    rst_n = 1;
    @(negedge clk);
    check(inhibit_reason == 3'd1, "R1 settle hold", inhibit_reason, 1);
    idle(10);
    check(inhibit_reason == 3'd0, "R7 ready after settle", inhibit_reason, 0);

    // R2 R3 R9: width sweep
    nst = 1; st[0] = 0;
    for (int w = 1; w <= 5; w++) begin
      cfg_min_width = 8'(w);
      for (int n = 1; n <= 7; n++) begin
        run_seq(n, 2 + w + OUT_W + 8);
        check(rises == ((n >= w) ? 1 : 0), "R2 qualify", rises, (n >= w) ? 1 : 0);
        if (n >= w && rises == 1) begin
          check(rise_at[0] == 2 + w, "R2 latency", rise_at[0], 2 + w);
          check(hi_total == OUT_W, "R3 width", hi_total, OUT_W);
          check(tsv[0] && ts_seen[0] == ts_exp[0], "R9 timestamp", ts_seen[0], ts_exp[0]);
        end
      end
    end
    check(drop_count == 0, "R6 no drops in sweep", drop_count, 0);

    // R3: stuck-high input gives one event
    cfg_min_width = 8'd1;
    run_seq(60, 70);
    check(rises == 1 && hi_total == OUT_W, "R3 long input single", hi_total, OUT_W);

    // R4: gap sweep
    cfg_min_width = 8'd2; cfg_min_gap = 12'd22; nst = 2; st[0] = 0;
    for (int d = 18; d <= 27; d++) begin
      st[1] = d;
      run_seq(3, d + 30);
      check(rises == ((d >= 22) ? 2 : 1), "R4 gap", rises, (d >= 22) ? 2 : 1);
      if (rises == 2) check(rise_at[1] - rise_at[0] == d, "R4 spacing", rise_at[1] - rise_at[0], d);
      if (d < 22) exp_drop++;
      check(drop_count == sat_drop(exp_drop), "R6 drop after gap", drop_count, sat_drop(exp_drop));
    end

    // R5: rate limit, bucket of 4, refill 200
    cfg_min_gap = 12'd2; cfg_refill = 16'd200; nst = 9;
    for (int k = 0; k < 9; k++) st[k] = 30 * k;
    run_seq(2, 270);
    check(rises == 5, "R5 rate count", rises, 5);
    if (rises == 5) check(rise_at[4] - rise_at[0] == 210, "R5 refill event", rise_at[4] - rise_at[0], 210);
    exp_drop += 4;
    check(drop_count == sat_drop(exp_drop), "R6 saturate", drop_count, SAT);
    cfg_refill = 16'd1;
    idle(10);

    // R7: single faults and priority, no output while inhibited
    nst = 1; st[0] = 0;
    for (int f = 0; f < 4; f++) begin
      int code;
      case (f)
        0: begin permit_raw = 0; code = 5; end
        1: begin health_raw = 0; code = 4; end
        2: begin line_raw = 0;   code = 3; end
        default: begin pwr_raw = 0; code = 2; end
      endcase
      idle(5);
      check(inhibit_reason == 3'(code), "R7 reason", inhibit_reason, code);
      run_seq(4, 30);
      check(rises == 0, "R8 inhibited no output", rises, 0);
      check(drop_count == sat_drop(exp_drop), "R6 not counted when inhibited", drop_count, sat_drop(exp_drop));
      permit_raw = 1; health_raw = 1; line_raw = 1; pwr_raw = 1;
      idle(6);
      check(inhibit_reason == 3'd0, "R7 clear", inhibit_reason, 0);
    end
    permit_raw = 0; health_raw = 0; idle(5);
    check(inhibit_reason == 3'd4, "R7 priority health", inhibit_reason, 4);
    line_raw = 0; idle(5);
    check(inhibit_reason == 3'd3, "R7 priority line", inhibit_reason, 3);
    pwr_raw = 0; idle(5);
    check(inhibit_reason == 3'd2, "R7 priority power", inhibit_reason, 2);
    permit_raw = 1; health_raw = 1; line_raw = 1; pwr_raw = 1;
    idle(8);

    // R8: cut-off mid pulse, reason latency
    begin
      int hi_after = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (i == 4) check(trig_out == 1, "R8 pulse started", trig_out, 1);
        if (i == 7) check(trig_out == 1 && inhibit_reason == 0, "R7 latency hold", inhibit_reason, 0);
        if (i == 8) check(trig_out == 0 && inhibit_reason == 3'd5, "R8 cut-off", inhibit_reason, 5);
        if (i >= 12 && trig_out) hi_after++;
        trig_raw = (i < 3);
        if (i == 5) permit_raw = 0;
        if (i == 9) permit_raw = 1;
      end
      check(hi_after == 0 && inhibit_reason == 0, "R8 no resume", hi_after, 0);
    end
    idle(30);

    // R10: back-pressure on timestamp slot
    ts_ready = 0; nst = 2; st[0] = 0; st[1] = 30;
    run_seq(3, 60);
    check(rises == 1, "R10 slot full drops", rises, 1);
    exp_drop++;
    check(ts_valid == 1 && ts_data == ts_exp[0], "R10 held word", ts_data, ts_exp[0]);
    ts_ready = 1;
    @(negedge clk);
    check(ts_valid == 0, "R10 popped", ts_valid, 0);
    check(drop_count == sat_drop(exp_drop), "R6 final", drop_count, sat_drop(exp_drop));

    // R1: reset during active pulse
    nst = 1; st[0] = 0;
    fork
      run_seq(3, 20);
      begin idle(8); rst_n = 0; end
    join
    #1;
    check(trig_out == 0 && inhibit_reason == 3'd1, "R1 mid reset", inhibit_reason, 1);
    check(drop_count == 0 && ts_valid == 0, "R1 mid reset clear", drop_count, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule